// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt sources and produces two request lines for a processor: a normal interrupt line and a fast interrupt line. Each line has its own enable mask over the same source vector. The line is raised whenever any enabled source is active. Software programs the two masks through a small word-indexed register port. It writes ones to a set register or to a clear register, so no read-modify-write is needed. It can read the raw source vector and the masked view seen by each line.

Source 0 can also be raised from software. A one-bit soft request register is set and cleared through two further registers. It is ORed with hardware input 0 to form level bit 0, so either agent can hold that source active. Requests to word indices that the block does not define complete normally with zero data. They also raise a one-cycle error pulse.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, both enable masks and the soft request are zero. Both request outputs, the error pulse and the read data are also zero.
- R2: The normal request output, on the cycle after each clock edge, equals the OR over all sources of (level AND normal mask) sampled at that edge. Level is the hardware input vector with bit 0 ORed with the soft request.
- R3: The fast request output follows the same rule using the fast mask.
- R4: A write to word index 2 sets every normal-mask bit where the write data holds a one. A write to index 3 clears every normal-mask bit where the data holds a one. Bits where the data holds a zero keep their value. A read of index 2 returns the normal mask.
- R5: Word indices 10 and 11 set and clear the fast mask in the same way. A read of index 10 returns the fast mask.
- R6: A write to index 4 with data bit 0 set makes the soft request one. A write to index 5 with data bit 0 set makes it zero. Either write with bit 0 clear leaves it unchanged. A read of index 4 returns level bit 0 in data bit 0, with zeros above it.
- R7: Reads of index 1 and index 9 both return the level vector.
- R8: A read of index 0 returns level AND normal mask. A read of index 8 returns level AND fast mask.
- R9: Reads of indices 3, 5 and 11, and of every undefined index, return zero. Writes to indices 0, 1, 8 and 9 change no state.
- R10: The error output is high for exactly the one cycle after a request, read or write, to an index outside {0..5, 8..11}. It is low otherwise.
- R11: Read data appears on the cycle after the read request, using the state from before that edge. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | N_SRC | Hardware interrupt source levels |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | ADDR_W | Word index (byte offset divided by 4) |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| bad_access | output | 1 | One-cycle pulse for an undefined index |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The properties assume that the source inputs and the request fields are stable and known at each rising edge. They also assume that a request lasts exactly one cycle, so that each accepted request is a single event. The stimulus meets these assumptions by changing every input only on the falling edge. A request is valid for one cycle, and a fresh source vector and request can be drawn on every cycle. Index draws are weighted toward the defined window and also reach the holes and the top of the index space. The soft request is exercised both while hardware input 0 is high and while it is low.

// File: rtl/irqf_pkg.sv
// Shared constants for the dual-output interrupt controller.
// Assumes: word indices are small integers compared against ADDR_W-wide fields.
package irqf_pkg;
    localparam int NUM_CH      = 2;   // channel 0 = normal request, 1 = fast request
    localparam int CH_STRIDE   = 8;   // word distance between the two channel groups
    localparam int OFS_MASKED  = 0;   // per-channel: masked status
    localparam int OFS_RAW     = 1;   // per-channel: raw level
    localparam int OFS_EN_SET  = 2;   // per-channel: enable set / enable readback
    localparam int OFS_EN_CLR  = 3;   // per-channel: enable clear (write only)
    localparam int IDX_SOFT_ON  = 4;  // soft request set / level bit 0 readback
    localparam int IDX_SOFT_OFF = 5;  // soft request clear (write only)

    // Word index of a channel register.
    function automatic int ch_index(input int ch, input int ofs);
        return ch * CH_STRIDE + ofs;
    endfunction
endpackage

// File: rtl/irqf_enable_bank.sv
// Write-one-to-set / write-one-to-clear enable mask for one request channel.
// Assumes: set and clear strobes are never both high (different word indices).
module irqf_enable_bank #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] en_q
);
    // Mask register: ones in wbits set or clear bits, zeros keep them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_stb) begin
            en_q <= en_q | wbits;
        end else if (clr_stb) begin
            en_q <= en_q & ~wbits;
        end
    end
endmodule

// File: rtl/irqf_soft_src.sv
// One-bit software request that is ORed into source 0.
// Assumes: on and off strobes are never both high.
module irqf_soft_src (
    input  logic clk,
    input  logic rst_n,
    input  logic on_stb,
    input  logic off_stb,
    input  logic wbit0,
    output logic soft_q
);
    // Soft request flag: only a write with data bit 0 set acts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (on_stb && wbit0) begin
            soft_q <= 1'b1;
        end else if (off_stb && wbit0) begin
            soft_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irqf_out_stage.sv
// Registered request line: high when any enabled source is active.
// Assumes: level and mask are stable at the clock edge.
module irqf_out_stage #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] level,
    input  logic [N_SRC-1:0] mask,
    output logic             req_q
);
    logic any_hit;

    // Reduction of the masked level vector.
    always_comb any_hit = |(level & mask);

    // Output flop: one cycle from level or mask change to the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= any_hit;
    end
endmodule

// File: rtl/irqf_read_mux.sv
// Combinational read decode: value for a word index and whether it is defined.
// Assumes: N_SRC <= DATA_W; write-only indices are defined but read as zero.
module irqf_read_mux #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]                      idx,
    input  logic [N_SRC-1:0]                       level,
    input  logic [irqf_pkg::NUM_CH-1:0][N_SRC-1:0] en,
    output logic [DATA_W-1:0]                      value,
    output logic                                   defined
);
    import irqf_pkg::*;

    // Select the read value for the addressed register.
    always_comb begin
        value   = '0;
        defined = 1'b0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (idx == ADDR_W'(ch_index(ch, OFS_MASKED))) begin
                value[N_SRC-1:0] = level & en[ch];
                defined          = 1'b1;
            end
            if (idx == ADDR_W'(ch_index(ch, OFS_RAW))) begin
                value[N_SRC-1:0] = level;
                defined          = 1'b1;
            end
            if (idx == ADDR_W'(ch_index(ch, OFS_EN_SET))) begin
                value[N_SRC-1:0] = en[ch];
                defined          = 1'b1;
            end
            if (idx == ADDR_W'(ch_index(ch, OFS_EN_CLR))) begin
                defined = 1'b1;
            end
        end
        if (idx == ADDR_W'(IDX_SOFT_ON)) begin
            value[0] = level[0];
            defined  = 1'b1;
        end
        if (idx == ADDR_W'(IDX_SOFT_OFF)) begin
            defined = 1'b1;
        end
    end
endmodule

// File: rtl/irq_fiq_ctrl.sv
// Dual-output level interrupt controller: two enable masks over one level
// vector, a soft request on source 0, a registered read port and an error
// pulse for undefined word indices.
// Assumes: requests last one cycle; req_word is already a word index.
module irq_fiq_ctrl #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_level,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_word,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              bad_access,
    output logic              irq_out,
    output logic              fiq_out
);
    import irqf_pkg::*;

    localparam int CH_IRQ = 0;
    localparam int CH_FIQ = 1;

    logic                          wr_stb;
    logic                          rd_stb;
    logic                          soft_q;
    logic [N_SRC-1:0]              level_w;
    logic [NUM_CH-1:0][N_SRC-1:0]  en_q;
    logic [NUM_CH-1:0]             req_q;
    logic [DATA_W-1:0]             rd_value;
    logic                          idx_defined;
    logic [N_SRC-1:0]              irq_en_q;
    logic [N_SRC-1:0]              fiq_en_q;

    // Request qualifiers.
    always_comb begin
        wr_stb = req_valid && req_write;
        rd_stb = req_valid && !req_write;
    end

    // Level vector: hardware inputs with the soft request folded into bit 0.
    always_comb begin
        level_w    = src_level;
        level_w[0] = src_level[0] | soft_q;
    end

    irqf_soft_src u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_stb  (wr_stb && (req_word == ADDR_W'(IDX_SOFT_ON))),
        .off_stb (wr_stb && (req_word == ADDR_W'(IDX_SOFT_OFF))),
        .wbit0   (req_wdata[0]),
        .soft_q  (soft_q)
    );

    // One mask bank and one output stage per request channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        irqf_enable_bank #(.N_SRC(N_SRC)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (wr_stb && (req_word == ADDR_W'(ch_index(ch, OFS_EN_SET)))),
            .clr_stb (wr_stb && (req_word == ADDR_W'(ch_index(ch, OFS_EN_CLR)))),
            .wbits   (req_wdata[N_SRC-1:0]),
            .en_q    (en_q[ch])
        );

        irqf_out_stage #(.N_SRC(N_SRC)) u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .level (level_w),
            .mask  (en_q[ch]),
            .req_q (req_q[ch])
        );
    end

    irqf_read_mux #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rmux (
        .idx     (req_word),
        .level   (level_w),
        .en      (en_q),
        .value   (rd_value),
        .defined (idx_defined)
    );

    // Named views of the masks for the checker.
    always_comb begin
        irq_en_q = en_q[CH_IRQ];
        fiq_en_q = en_q[CH_FIQ];
        irq_out  = req_q[CH_IRQ];
        fiq_out  = req_q[CH_FIQ];
    end

    // Read data register: loads on a read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= rd_value;
    end

    // Error pulse: any request to an undefined index.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_access <= 1'b0;
        else        bad_access <= req_valid && !idx_defined;
    end
endmodule

// File: rtl/irqf_checker.sv
// Properties for irq_fiq_ctrl, bound to every instance of it.
// Assumes: inputs are stable at each rising edge.
module irqf_checker #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_level,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_word,
    input logic [DATA_W-1:0] req_wdata,
    input logic              soft_q,
    input logic [N_SRC-1:0]  irq_en_q,
    input logic [N_SRC-1:0]  fiq_en_q,
    input logic              irq_out,
    input logic              fiq_out,
    input logic              bad_access
);
    logic wr_any;
    logic wr_status;
    logic [N_SRC-1:0] wbits;

    always_comb begin
        wr_any    = req_valid && req_write;
        wr_status = wr_any && (req_word == ADDR_W'(0) || req_word == ADDR_W'(1) ||
                               req_word == ADDR_W'(8) || req_word == ADDR_W'(9));
        wbits     = req_wdata[N_SRC-1:0];
    end

    AST_MASKS_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_en_q == '0 && fiq_en_q == '0 && !soft_q)); // R1

    AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(((src_level & irq_en_q) != '0) || (soft_q && irq_en_q[0]))); // R2

    AST_FIQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_out == $past(((src_level & fiq_en_q) != '0) || (soft_q && fiq_en_q[0]))); // R3

    AST_IRQ_EN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && req_word == ADDR_W'(2)) |=> ((irq_en_q & $past(wbits)) == $past(wbits))); // R4

    AST_IRQ_EN_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && req_word == ADDR_W'(3)) |=> ((irq_en_q & $past(wbits)) == '0)); // R4

    AST_FIQ_EN_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && req_word == ADDR_W'(10)) |=> ((fiq_en_q & $past(wbits)) == $past(wbits))); // R5

    AST_FIQ_EN_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && req_word == ADDR_W'(11)) |=> ((fiq_en_q & $past(wbits)) == '0)); // R5

    AST_SOFT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && req_word == ADDR_W'(4) && req_wdata[0]) |=> soft_q); // R6

    AST_SOFT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && req_word == ADDR_W'(5) && req_wdata[0]) |=> !soft_q); // R6

    AST_STATUS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ($stable(irq_en_q) && $stable(fiq_en_q) && $stable(soft_q))); // R9

    AST_ERROR_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(req_valid)); // R10
endmodule

bind irq_fiq_ctrl irqf_checker #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irqf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_level  (src_level),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_word   (req_word),
    .req_wdata  (req_wdata),
    .soft_q     (soft_q),
    .irq_en_q   (irq_en_q),
    .fiq_en_q   (fiq_en_q),
    .irq_out    (irq_out),
    .fiq_out    (fiq_out),
    .bad_access (bad_access)
);

// File: tb/test_irq_fiq_ctrl.sv
// Bench: behavioural reference model updated at each rising edge and
// compared against the outputs at every falling edge.
module test_irq_fiq_ctrl;
    localparam int N_SRC  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src_level = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_word = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rd_data;
    logic              bad_access;
    logic              irq_out;
    logic              fiq_out;

    int checks = 0;
    int errors = 0;
    bit compare_on = 1'b0;

    // Reference state.
    logic [31:0] m_ien = '0, m_fen = '0;
    bit          m_soft = 1'b0;
    bit          e_irq = 1'b0, e_fiq = 1'b0, e_bad = 1'b0;
    logic [31:0] e_rd = '0;
    int          last_rd_idx = -1;

    always #10 clk = ~clk;

    irq_fiq_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_irq_fiq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .req_valid(req_valid),
        .req_write(req_write), .req_word(req_word), .req_wdata(req_wdata),
        .rd_data(rd_data), .bad_access(bad_access), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    function automatic bit known_idx(input int i);
        return (i >= 0 && i <= 5) || (i >= 8 && i <= 11);
    endfunction

    function automatic string rd_tag(input int i);
        case (i)
            0, 8:    return "R8 R11";
            1, 9:    return "R7 R11";
            2:       return "R4 R11";
            10:      return "R5 R11";
            4:       return "R6 R11";
            -1:      return "R1 R11";
            default: return "R9 R11";
        endcase
    endfunction

    // Reference model: next expected outputs from pre-edge inputs and state.
    always @(posedge clk) begin
        logic [31:0] lvl;
        int          idx;
        lvl    = src_level;
        lvl[0] = src_level[0] | m_soft;
        idx    = int'(req_word);
        if (!rst_n) begin
            m_ien = '0; m_fen = '0; m_soft = 1'b0;
            e_irq = 1'b0; e_fiq = 1'b0; e_bad = 1'b0; e_rd = '0; last_rd_idx = -1;
        end else begin
            e_irq = (lvl & m_ien) != 0;
            e_fiq = (lvl & m_fen) != 0;
            e_bad = req_valid && !known_idx(idx);
            if (req_valid && !req_write) begin
                last_rd_idx = idx;
                case (idx)
                    0:  e_rd = lvl & m_ien;
                    1:  e_rd = lvl;
                    2:  e_rd = m_ien;
                    4:  e_rd = {31'b0, lvl[0]};
                    8:  e_rd = lvl & m_fen;
                    9:  e_rd = lvl;
                    10: e_rd = m_fen;
                    default: e_rd = '0;
                endcase
            end
            if (req_valid && req_write) begin
                case (idx)
                    2:  m_ien = m_ien | req_wdata;
                    3:  m_ien = m_ien & ~req_wdata;
                    10: m_fen = m_fen | req_wdata;
                    11: m_fen = m_fen & ~req_wdata;
                    4:  if (req_wdata[0]) m_soft = 1'b1;
                    5:  if (req_wdata[0]) m_soft = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the rising edge.
    always @(negedge clk) begin
        if (compare_on) begin
            chk(irq_out == e_irq, "R2 normal request", 32'(irq_out), 32'(e_irq));
            chk(fiq_out == e_fiq, "R3 fast request", 32'(fiq_out), 32'(e_fiq));
            chk(bad_access == e_bad, "R10 error pulse", 32'(bad_access), 32'(e_bad));
            chk(rd_data == e_rd, rd_tag(last_rd_idx), rd_data, e_rd);
        end
    end

    task automatic op(input bit v, input bit w, input int idx, input logic [31:0] d);
        req_valid = v; req_write = w; req_word = ADDR_W'(idx); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports.
        chk(irq_out == 1'b0, "R1 normal request in reset", 32'(irq_out), 0);
        chk(fiq_out == 1'b0, "R1 fast request in reset", 32'(fiq_out), 0);
        chk(bad_access == 1'b0, "R1 error in reset", 32'(bad_access), 0);
        chk(rd_data == '0, "R1 read data in reset", rd_data, 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        // R1: masks read as zero right after reset.
        op(1, 0, 2, 0);
        op(1, 0, 10, 0);
        // R4/R2: enable bits 4..7, raise source 4.
        op(1, 1, 2, 32'h0000_00F0);
        src_level = 32'h0000_0010;
        idle(2);
        op(1, 0, 0, 0);   // R8 masked normal status
        op(1, 0, 2, 0);   // R4 readback
        op(1, 1, 3, 32'h0000_0030);  // R4 partial clear
        op(1, 0, 2, 0);
        // R5/R3: fast mask on bit 0, soft request with hardware input 0 low.
        src_level = '0;
        op(1, 1, 10, 32'h0000_0001);
        op(1, 1, 4, 32'h0000_0001);  // R6 raise soft
        op(1, 0, 4, 0);
        op(1, 0, 9, 0);              // R7 raw view
        op(1, 0, 8, 0);              // R8 masked fast status
        op(1, 1, 5, 32'hFFFF_FFFE);  // R6 bit 0 clear: no effect
        op(1, 0, 4, 0);
        src_level = 32'h0000_0001;   // hardware and soft both drive source 0
        op(1, 1, 5, 32'h0000_0001);  // R6 drop soft, hardware keeps it
        op(1, 0, 1, 0);
        src_level = '0;
        op(1, 0, 4, 0);
        // R9: status writes ignored, write-only and holes read zero.
        op(1, 1, 0, 32'hFFFF_FFFF);
        op(1, 1, 1, 32'hFFFF_FFFF);
        op(1, 1, 8, 32'hFFFF_FFFF);
        op(1, 1, 9, 32'hFFFF_FFFF);
        op(1, 0, 2, 0);
        op(1, 0, 10, 0);
        op(1, 0, 3, 0);
        op(1, 0, 5, 0);
        op(1, 0, 11, 0);
        // R10: undefined indices, read and write.
        op(1, 0, 6, 0);
        op(1, 1, 7, 32'hFFFF_FFFF);
        op(1, 0, 12, 0);
        op(1, 0, 63, 0);
        op(1, 1, 2, 32'hFFFF_FFFF);
        op(1, 1, 11, 32'hFFFF_FFFF);
        idle(2);
        // Mixed traffic.
        for (int n = 0; n < 5000; n++) begin
            int sel;
            int idx;
            sel = int'($urandom_range(0, 9));
            idx = (sel < 8) ? int'($urandom_range(0, 11)) : int'($urandom_range(0, 63));
            src_level = ($urandom_range(0, 3) == 0) ? $urandom : (32'h1 << $urandom_range(0, 31)) & $urandom;
            req_valid = ($urandom_range(0, 3) != 0);
            req_write = $urandom_range(0, 1) == 1;
            req_word  = ADDR_W'(idx);
            req_wdata = ($urandom_range(0, 1) == 1) ? $urandom : (32'h1 << $urandom_range(0, 31));
            @(negedge clk);
        end
        req_valid = 1'b0;
        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule